// File: doc/BRIEF.md
# Multiplexed ROM Bus Controller

This block reads bytes from an external byte-wide ROM or Flash device through one shared 8-bit bus. The bus is split into an output path (`bus_out` with enable `bus_oe`) and an input path (`bus_in`). An external tristate buffer joins the two paths at the pad. The same wires carry the address, one byte at a time, into external 8-bit holding registers, each clocked by its own strobe. After the address is in place, the same wires carry the data byte back from the memory.

Pull-up straps on the bus tell the controller the size and speed of the memory. The controller samples these straps once, a fixed number of cycles after reset is released. While it waits it drives nothing onto the bus and accepts no request. After sampling, it serves single-byte read requests from an internal valid/ready request port and answers with a one-cycle response pulse. A request for an address that lies beyond the sensed memory size gets an error response, and no bus cycle takes place. The interface is meant for slow bulk loading, such as copying code out of ROM, and not for executing code directly from the memory.

The controller is built around one state machine:
- `ST_STRAP` waits for strap sampling.
- `ST_IDLE` accepts a request. An out-of-range request goes straight to `ST_RESP`; an in-range request goes to `ST_ASETUP`.
- Each address byte passes through `ST_ASETUP` (byte driven), then `ST_ASTRB` (strobe high), then `ST_AHOLD` (byte still driven).
- `ST_AHOLD` returns to `ST_ASETUP` for the next byte, or moves to `ST_READ` after the last byte.
- `ST_READ` keeps the read enable high for the programmed number of cycles, then moves to `ST_RESP`.
- `ST_RESP` presents the response and returns to `ST_IDLE`.

Top module: `rom_bus_ctrl`

## Requirements
- R1: The bus is sampled on the 4th rising clock edge after reset is released, and `cfg_done` rises at that edge. Until `cfg_done` is high, `bus_oe`, `req_ready` and every address strobe stay low, and a pending request is not accepted.
- R2: Strap bits [2:0] give the memory size as 16 KB shifted left by the code (0 = 16 KB up to 6 = 1 MB). Code 7 acts as 1 MB. Strap bits [7:5] have no effect.
- R3: A request with an address at or above the sensed size produces `rsp_valid` with `rsp_err` = 1 in the cycle after it is accepted. No address strobe and no read enable are produced for it.
- R4: An in-range request sends two address bytes when the size is 64 KB or less, and three bytes otherwise. The bytes go out in order: low byte on `addr_stb[0]`, middle byte on `addr_stb[1]`, high byte on `addr_stb[2]`. The high byte carries address bits [19:16] in its low nibble and zeros above them.
- R5: Each address strobe is high for exactly one cycle, and at most one strobe is high at a time. The byte it latches is on `bus_out`, with `bus_oe` high, from the cycle before the strobe through the cycle after it.
- R6: In the read phase `bus_oe` is low and `rom_rd_en` is high for 2 + W cycles, where W is strap bits [4:3]. `rsp_data` is the value of `bus_in` in the last of those cycles.
- R7: Each request produces exactly one response, a one-cycle `rsp_valid` pulse with `rsp_err` = 0 for an in-range request. The pulse arrives 1 + 3·P + (2 + W) edges after acceptance, where P is the number of address bytes. `req_ready` is high only while idle.
- R8: `rom_wr_en` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 20 | Byte address of the request |
| req_ready | output | 1 | Controller idle; a request is accepted on this edge |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 8 | Byte read from memory |
| rsp_err | output | 1 | Address was beyond the sensed size |
| bus_in | input | 8 | Shared bus as seen at the pad (straps, read data) |
| bus_out | output | 8 | Address byte driven onto the shared bus |
| bus_oe | output | 1 | Enables the pad drivers for `bus_out` |
| addr_stb | output | 3 | Clock strobes of the low, middle and high address holding registers |
| rom_rd_en | output | 1 | Memory read enable |
| rom_wr_en | output | 1 | Memory write enable (held inactive) |
| cfg_done | output | 1 | Straps have been sampled |

## Verification
The assertions assume that the strap levels are steady around the sampling edge and that `bus_in` carries the memory data in the last read-enable cycle. The bench holds the strap value from before reset until `cfg_done` is seen. Its memory model puts valid data on the bus only in the final read cycle and puts zero in every other cycle, so capturing the data too early or too late is caught. Requests are raised only while `req_ready` is observed high and are dropped right after acceptance, so the assertions never see a request overlapping a busy controller.

// File: rtl/rom_bus_pkg.sv
`timescale 1ns/1ps
package rom_bus_pkg;
    localparam int SIZE_W = 3;
    localparam int WAIT_W = 2;

    typedef enum logic [2:0] {
        ST_STRAP,
        ST_IDLE,
        ST_ASETUP,
        ST_ASTRB,
        ST_AHOLD,
        ST_READ,
        ST_RESP
    } rom_state_e;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_code;
        logic [SIZE_W-1:0] size_code;
    } rom_cfg_t;
endpackage

// File: rtl/rom_strap_sampler.sv
`timescale 1ns/1ps
module rom_strap_sampler
    import rom_bus_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int STRAP_DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_in,
    output logic             cfg_done,
    output rom_cfg_t         cfg
);
    localparam int CNT_W  = $clog2(STRAP_DELAY + 1);
    localparam int USED_W = SIZE_W + WAIT_W;

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    rom_cfg_t         cfg_q;
    logic             unused_hi;

    // Bits above the size and wait fields are pulled up but carry no meaning.
    assign unused_hi = ^bus_in[BUS_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            cfg_q  <= '0;
        end else if (!done_q) begin
            if (cnt_q == CNT_W'(STRAP_DELAY - 1)) begin
                done_q <= 1'b1;
                cfg_q  <= rom_cfg_t'(bus_in[USED_W-1:0]);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cfg_done = done_q;
    assign cfg      = cfg_q;

    // R2: the sampled straps never change once sampling is complete
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done && $stable(cfg));
endmodule

// File: rtl/rom_range_check.sv
`timescale 1ns/1ps
module rom_range_check
    import rom_bus_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BASE_LOG2 = 14,
    parameter int NUM_LAT   = 3,
    parameter int IDX_W     = 2
) (
    input  logic [SIZE_W-1:0] size_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              out_of_range,
    output logic [IDX_W-1:0]  last_idx
);
    localparam int MAX_CODE = ADDR_W - BASE_LOG2;
    localparam int EXP_W    = $clog2(ADDR_W + 8) + 1;

    logic [SIZE_W-1:0] eff_code;
    logic [EXP_W-1:0]  size_log2;
    logic [EXP_W-1:0]  n_bytes;

    always_comb begin
        eff_code     = (size_code > SIZE_W'(MAX_CODE)) ? SIZE_W'(MAX_CODE) : size_code;
        size_log2    = EXP_W'(BASE_LOG2) + EXP_W'(eff_code);
        out_of_range = (addr >> size_log2) != '0;
        n_bytes      = (size_log2 + EXP_W'(7)) >> 3;
        last_idx     = IDX_W'(n_bytes - EXP_W'(1));
    end

    // R4: the number of address bytes stays within the available holding registers
    assert_lat_count_R4: assert final (32'(last_idx) < NUM_LAT);
endmodule

// File: rtl/rom_cycle_fsm.sv
`timescale 1ns/1ps
module rom_cycle_fsm
    import rom_bus_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BUS_W   = 8,
    parameter int NUM_LAT = 3,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic [WAIT_W-1:0] wait_code,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              req_oor,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_data,
    output logic              rsp_err,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe,
    output logic [NUM_LAT-1:0] addr_stb,
    output logic              rom_rd_en,
    output logic              rom_wr_en
);
    localparam int PAD_W = NUM_LAT * BUS_W;
    localparam int CNT_W = WAIT_W + 1;

    rom_state_e        state_q, state_d;
    logic [PAD_W-1:0]  addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  rd_last;
    logic [BUS_W-1:0]  data_q;
    logic              err_q;

    // read phase spans 2 + wait cycles: counter runs 0 .. wait+1
    assign rd_last = {1'b0, wait_code} + CNT_W'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STRAP:  if (cfg_done) state_d = ST_IDLE;
            ST_IDLE:   if (req_valid) state_d = req_oor ? ST_RESP : ST_ASETUP;
            ST_ASETUP: state_d = ST_ASTRB;
            ST_ASTRB:  state_d = ST_AHOLD;
            ST_AHOLD:  state_d = (idx_q == last_idx) ? ST_READ : ST_ASETUP;
            ST_READ:   if (cnt_q == rd_last) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_STRAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STRAP;
            addr_q  <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q <= PAD_W'(req_addr);
                    err_q  <= req_oor;
                    idx_q  <= '0;
                end
                ST_AHOLD: begin
                    idx_q <= idx_q + 1'b1;
                    cnt_q <= '0;
                end
                ST_READ: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == rd_last) data_q <= bus_in;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_oe    = (state_q == ST_ASETUP) || (state_q == ST_ASTRB) || (state_q == ST_AHOLD);
        bus_out   = bus_oe ? addr_q[{idx_q, 3'b000} +: BUS_W] : '0;
        rom_rd_en = (state_q == ST_READ);
        rom_wr_en = 1'b0;
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_data  = data_q;
        rsp_err   = err_q;
    end

    for (genvar g = 0; g < NUM_LAT; g++) begin : g_stb
        assign addr_stb[g] = (state_q == ST_ASTRB) && (idx_q == IDX_W'(g));
    end

    // R5: one holding register clocked at a time
    assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(addr_stb));
    // R5: strobes last a single cycle
    assert_stb_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|addr_stb) |=> (addr_stb == '0));
    // R5: byte already driven in the cycle before the strobe
    assert_stb_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|addr_stb) |-> bus_oe && $past(bus_oe) && $stable(bus_out));
    // R5: byte still driven in the cycle after the strobe
    assert_stb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|addr_stb) |=> bus_oe && $stable(bus_out));
    // R6: drivers released while the memory drives the bus
    assert_rd_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_en |-> !bus_oe);
    // R3: an error response follows acceptance directly, with no bus cycle
    assert_err_no_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> $past(req_ready) && !$past(rom_rd_en));
    // R7: responses are single-cycle pulses
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R7: no acceptance while a response is presented
    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

// File: rtl/rom_bus_ctrl.sv
`timescale 1ns/1ps
module rom_bus_ctrl
    import rom_bus_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int BUS_W       = 8,
    parameter int BASE_LOG2   = 14,
    parameter int STRAP_DELAY = 4,
    localparam int NUM_LAT    = (ADDR_W + BUS_W - 1) / BUS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [BUS_W-1:0]   rsp_data,
    output logic               rsp_err,
    input  logic [BUS_W-1:0]   bus_in,
    output logic [BUS_W-1:0]   bus_out,
    output logic               bus_oe,
    output logic [NUM_LAT-1:0] addr_stb,
    output logic               rom_rd_en,
    output logic               rom_wr_en,
    output logic               cfg_done
);
    localparam int IDX_W = (NUM_LAT > 1) ? $clog2(NUM_LAT) : 1;

    rom_cfg_t         cfg;
    logic             req_oor;
    logic [IDX_W-1:0] last_idx;

    rom_strap_sampler #(
        .BUS_W      (BUS_W),
        .STRAP_DELAY(STRAP_DELAY)
    ) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_in  (bus_in),
        .cfg_done(cfg_done),
        .cfg     (cfg)
    );

    rom_range_check #(
        .ADDR_W   (ADDR_W),
        .BASE_LOG2(BASE_LOG2),
        .NUM_LAT  (NUM_LAT),
        .IDX_W    (IDX_W)
    ) u_range (
        .size_code   (cfg.size_code),
        .addr        (req_addr),
        .out_of_range(req_oor),
        .last_idx    (last_idx)
    );

    rom_cycle_fsm #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .NUM_LAT(NUM_LAT),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_done (cfg_done),
        .wait_code(cfg.wait_code),
        .last_idx (last_idx),
        .req_oor  (req_oor),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .rsp_err  (rsp_err),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .addr_stb (addr_stb),
        .rom_rd_en(rom_rd_en),
        .rom_wr_en(rom_wr_en)
    );

    // R1: no driving and no acceptance before the straps are known
    assert_quiet_before_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !bus_oe && !req_ready && (addr_stb == '0));
endmodule

// File: tb/rom_bus_ctrl_bench.sv
`timescale 1ns/1ps
module rom_bus_ctrl_bench;
    typedef struct packed {
        logic [7:0]  strap;
        logic [19:0] addr;
        logic        err;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 20'h00123, 1'b0},
        '{8'h00, 20'h04000, 1'b1},
        '{8'hE0, 20'h03FFF, 1'b0},
        '{8'h01, 20'h07FFF, 1'b0},
        '{8'h01, 20'h08000, 1'b1},
        '{8'h1A, 20'h0FFFF, 1'b0},
        '{8'h1A, 20'h10000, 1'b1},
        '{8'hAB, 20'h1ABCD, 1'b0},
        '{8'hAB, 20'h20000, 1'b1},
        '{8'h04, 20'h3FFFF, 1'b0},
        '{8'h04, 20'h40000, 1'b1},
        '{8'h05, 20'h80000, 1'b1},
        '{8'h05, 20'h7FFFF, 1'b0},
        '{8'h16, 20'hFFFFF, 1'b0},
        '{8'h17, 20'hFFFFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [7:0]  rsp_data;
    logic [7:0]  bus_in, bus_out;
    logic        bus_oe, rom_rd_en, rom_wr_en, cfg_done;
    logic [2:0]  addr_stb;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic       serving = 1'b0;
    logic [7:0] strap_val = 8'h00;
    int         rd_len_exp = 2;
    int         rd_cnt = 0;
    logic [7:0] ext_lat [3];

    always #2.5 clk = ~clk;

    rom_bus_ctrl u_rom_bus_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .rsp_err  (rsp_err),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .addr_stb (addr_stb),
        .rom_rd_en(rom_rd_en),
        .rom_wr_en(rom_wr_en),
        .cfg_done (cfg_done)
    );

    function automatic logic [7:0] rom_byte(logic [19:0] a);
        return (a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]}) + 8'h5A;
    endfunction

    // memory model: valid data only in the final read-enable cycle
    always_ff @(posedge clk) rd_cnt <= rom_rd_en ? rd_cnt + 1 : 0;

    always_comb begin
        if (!serving)
            bus_in = strap_val;
        else if (rom_rd_en && rd_cnt == rd_len_exp - 1)
            bus_in = rom_byte({ext_lat[2][3:0], ext_lat[1], ext_lat[0]});
        else
            bus_in = 8'h00;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [7:0] strap, input logic hold_req);
        int n = 0;
        int viol = 0;
        serving   = 1'b0;
        strap_val = strap;
        req_valid = hold_req;
        req_addr  = 20'h00010;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("reset state", {27'd0, bus_oe, rom_rd_en, |addr_stb, rsp_valid, cfg_done}, 32'd0);
        rst_n = 1'b1;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (bus_oe || req_ready || |addr_stb) viol++;
            if (cfg_done || n > 20) break;
        end
        check("R1 strap sample edge", n, 4);
        check("R1 quiet before sampling", viol, 0);
        req_valid = 1'b0;
        serving   = 1'b1;
    endtask

    task automatic run_vec(input vec_t v);
        logic [2:0] code;
        int eff, phases, wt, lat, stb_cnt, rd_cyc, busy_rdy, wr_seen, next_idx, order_bad;
        code   = v.strap[2:0];
        eff    = (code == 3'd7) ? 6 : int'(code);
        phases = (eff >= 3) ? 3 : 2;
        wt     = int'(v.strap[4:3]);
        rd_len_exp = 2 + wt;
        for (int i = 0; i < 3; i++) ext_lat[i] = 8'h00;
        stb_cnt = 0; rd_cyc = 0; busy_rdy = 0; wr_seen = 0; next_idx = 0; order_bad = 0;
        @(negedge clk);
        check("R7 ready when idle", {31'd0, req_ready}, 1);
        req_valid = 1'b1;
        req_addr  = v.addr;
        @(posedge clk);
        lat = 1;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 3; i++) begin
                if (addr_stb[i]) begin
                    ext_lat[i] = bus_out;
                    stb_cnt++;
                    if (i != next_idx) order_bad++;
                    next_idx++;
                end
            end
            if (rom_rd_en) rd_cyc++;
            if (req_ready) busy_rdy++;
            if (rom_wr_en) wr_seen++;
            if (rsp_valid || lat > 200) break;
            @(posedge clk);
            lat++;
        end
        check("R7 response seen", {31'd0, rsp_valid}, 1);
        check("R7 ready low while busy", busy_rdy, 0);
        check("R8 write enable idle", wr_seen, 0);
        if (v.err) begin
            check("R3 error flag", {31'd0, rsp_err}, 1);
            check("R3 error latency", lat, 1);
            check("R3 no strobes", stb_cnt, 0);
            check("R3 no read cycle", rd_cyc, 0);
        end else begin
            check("R2 in range no error", {31'd0, rsp_err}, 0);
            check("R4 address byte count", stb_cnt, phases);
            check("R4 address byte order", order_bad, 0);
            check("R4 latched address", {12'd0, ext_lat[2][3:0], ext_lat[1], ext_lat[0]},
                  {12'd0, v.addr});
            if (phases == 3) check("R4 high byte upper nibble", {28'd0, ext_lat[2][7:4]}, 0);
            check("R6 read enable length", rd_cyc, rd_len_exp);
            check("R6 data from last cycle", {24'd0, rsp_data}, {24'd0, rom_byte(v.addr)});
            check("R7 response latency", lat, 1 + 3 * phases + rd_len_exp);
        end
        @(posedge clk);
    endtask

    initial begin
        logic [7:0] cur;
        for (int i = 0; i < 3; i++) ext_lat[i] = 8'h00;
        // directed: reset state and a request held during strap sampling (R1)
        apply_reset(8'h00, 1'b1);
        cur = 8'h00;
        // vector table walk (R2..R8); a strap change forces a fresh reset
        for (int k = 0; k < NVEC; k++) begin
            if (VECS[k].strap != cur) begin
                apply_reset(VECS[k].strap, 1'b0);
                cur = VECS[k].strap;
            end
            run_vec(VECS[k]);
        end
        // directed: upper strap bits set must not change a 16 KB, no-wait part (R2)
        apply_reset(8'hF8 & 8'hE0, 1'b0);
        run_vec('{8'hE0, 20'h04000, 1'b1});
        run_vec('{8'hE0, 20'h00000, 1'b0});
        // directed: code 7 with maximum wait behaves as 1 MB (R2, R6)
        apply_reset(8'h1F, 1'b0);
        run_vec('{8'h1F, 20'h80001, 1'b0});
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule